// File: doc/BRIEF.md
# GPIO Port with Routed Interrupts

This block is a general-purpose I/O port of up to 32 lines behind a small 32-bit register bus. Software sets the value and the direction of each line, reads back the pad levels after synchronisation, and picks for every line whether and how it raises an interrupt. Each line has two configuration bits: a polarity bit and an edge bit. Together they select one of four trigger modes. A per-line mask bit gates the line, and a per-line index chooses which of the shared interrupt outputs the line drives.

Pad inputs pass through a two-flop synchroniser. Level triggers follow the synchronised, masked level. Edge triggers compare the synchronised value with the value one cycle earlier and give a single-cycle pulse. All lines that point at the same output index are OR-combined, and each interrupt output is registered. The bus is a single-cycle interface: writes take effect at the clock edge and read data is combinational from the address.

Top module: `gpio_irq_router`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, `pad_oe` and `irq_out` are 0, and all lines are inputs.
- R2: The output-value (0x04), direction (0x08), mask (0x0C), polarity (0x10) and edge-select (0x14) registers read back what was last written. Bit n always belongs to line n.
- R3: `pad_oe[n]` equals direction bit n and `pad_out[n]` equals output-value bit n, from the cycle after the write.
- R4: Reading offset 0x00 returns the pad inputs delayed by two clock edges, through the synchroniser.
- R5: With edge bit 0, a masked-in line asserts its routed output while its synchronised level is 1 (polarity 1) or 0 (polarity 0). The output is registered, so it rises three edges after the pad changes.
- R6: With edge bit 1, a masked-in line gives a pulse exactly one cycle long on its routed output. Polarity 1 selects a 0-to-1 transition and polarity 0 a 1-to-0 transition. The pulse appears on the third edge after the pad change.
- R7: A line whose mask bit is 0 has no effect on any interrupt output. With the whole mask clear, every output is 0 one cycle later.
- R8: Mapping words start at 0x20 with four lines per word. Line n uses word 0x20+4*(n/4), byte n%4, and bits [4:0] of that byte hold its output index. The upper three bits of each byte read as 0. Lines with the same index are OR-combined. An index at or above the number of outputs drives no output.
- R9: Offset 0x18 and addresses outside the map read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | NUM_LINES | Asynchronous pad inputs |
| pad_out | output | NUM_LINES | Output values to the pads |
| pad_oe | output | NUM_LINES | Output enables, 1 = drive |
| irq_out | output | NUM_IRQ | Registered interrupt outputs |

## Verification
The bench builds the block with NUM_LINES = 32 and NUM_IRQ = 4. Thirty-two lines fill all eight mapping words and every byte lane in them. Four outputs leave the 5-bit index codes 4 to 31 unrouted, so the random configurations mix routed lines, unrouted lines, and several lines sharing one output. Directed cases time the synchroniser latency and the edge pulse width. The random runs hold the pads steady and compare the settled outputs with a level model.

// File: rtl/gpio_irq_pkg.sv
// Shared constants, types and trigger evaluation for the GPIO interrupt router.
package gpio_irq_pkg;

    // Register byte offsets
    localparam logic [7:0] ADDR_DATA = 8'h00;
    localparam logic [7:0] ADDR_OUT  = 8'h04;
    localparam logic [7:0] ADDR_DIR  = 8'h08;
    localparam logic [7:0] ADDR_MASK = 8'h0C;
    localparam logic [7:0] ADDR_POL  = 8'h10;
    localparam logic [7:0] ADDR_EDGE = 8'h14;
    localparam logic [7:0] ADDR_MAP  = 8'h20;

    // Width of the stored routing index per line
    localparam int unsigned IDX_W = 5;

    // Trigger mode encoded as {edge, polarity}
    typedef enum logic [1:0] {
        TRIG_LVL_LOW  = 2'b00,
        TRIG_LVL_HIGH = 2'b01,
        TRIG_FALL     = 2'b10,
        TRIG_RISE     = 2'b11
    } trig_mode_e;

    // Evaluates one line's trigger from its current and previous level
    function automatic logic trig_hit(trig_mode_e mode, logic cur, logic prv);
        case (mode)
            TRIG_LVL_LOW:  return ~cur;
            TRIG_LVL_HIGH: return cur;
            TRIG_FALL:     return ~cur & prv;
            default:       return cur & ~prv;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a bus of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;
    logic [1:0]       warm_q;

    // Capture the pads and settle them through a second flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    // Counts cycles since reset so the latency check looks only at valid history
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= '0;
        else if (warm_q != 2'd3)
            warm_q <= warm_q + 2'd1;
    end

    assign q = stab_q;

    // R4
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_regfile.sv
// Register bank of the GPIO port: per-line control words, routing indices
// and a combinational read mux. Assumes word-aligned single-cycle accesses.
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_sel,
    input  logic                                bus_wr,
    input  logic [7:0]                          bus_addr,
    input  logic [31:0]                         bus_wdata,
    output logic [31:0]                         bus_rdata,
    input  logic [NUM_LINES-1:0]                sync_in,
    output logic [NUM_LINES-1:0]                out_q,
    output logic [NUM_LINES-1:0]                dir_q,
    output logic [NUM_LINES-1:0]                mask_q,
    output logic [NUM_LINES-1:0]                pol_q,
    output logic [NUM_LINES-1:0]                edge_q,
    output logic [NUM_LINES-1:0][IDX_W-1:0]     map_q
);

    localparam int unsigned MAP_WORDS = (NUM_LINES + 3) / 4;
    localparam logic [8:0]  MAP_END   = 9'(32 + 4 * MAP_WORDS);

    logic       wr_en;
    logic       map_hit;
    logic [7:0] map_off;
    logic [5:0] map_word;

    // Decode the mapping-word window
    always_comb begin
        map_off  = bus_addr - ADDR_MAP;
        map_word = map_off[7:2];
        map_hit  = (bus_addr >= ADDR_MAP) && ({1'b0, bus_addr} < MAP_END)
                   && (bus_addr[1:0] == 2'b00);
        wr_en    = bus_sel && bus_wr;
    end

    // Per-line control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
            pol_q  <= '0;
            edge_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                ADDR_OUT:  out_q  <= bus_wdata[NUM_LINES-1:0];
                ADDR_DIR:  dir_q  <= bus_wdata[NUM_LINES-1:0];
                ADDR_MASK: mask_q <= bus_wdata[NUM_LINES-1:0];
                ADDR_POL:  pol_q  <= bus_wdata[NUM_LINES-1:0];
                ADDR_EDGE: edge_q <= bus_wdata[NUM_LINES-1:0];
                default:   ;
            endcase
        end
    end

    // Routing index per line, one byte lane each within its word
    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_map
            always_ff @(posedge clk) begin
                if (!rst_n)
                    map_q[i] <= '0;
                else if (wr_en && map_hit && (map_word == 6'(i / 4)))
                    map_q[i] <= bus_wdata[8*(i%4) +: IDX_W];
            end
        end
    endgenerate

    // Read mux, zero for reserved and unmapped offsets
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_DATA: bus_rdata[NUM_LINES-1:0] = sync_in;
            ADDR_OUT:  bus_rdata[NUM_LINES-1:0] = out_q;
            ADDR_DIR:  bus_rdata[NUM_LINES-1:0] = dir_q;
            ADDR_MASK: bus_rdata[NUM_LINES-1:0] = mask_q;
            ADDR_POL:  bus_rdata[NUM_LINES-1:0] = pol_q;
            ADDR_EDGE: bus_rdata[NUM_LINES-1:0] = edge_q;
            default: begin
                if (map_hit) begin
                    for (int i = 0; i < int'(NUM_LINES); i++) begin
                        if (map_word == 6'(i / 4))
                            bus_rdata[8*(i%4) +: IDX_W] = map_q[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/gpio_trig_detect.sv
// Per-line trigger detection. Takes synchronised levels and keeps one cycle
// of history for edge modes. Output events are masked and unregistered.
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] level,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] pol,
    input  logic [NUM_LINES-1:0] edge_sel,
    output logic [NUM_LINES-1:0] evt
);

    logic [NUM_LINES-1:0] prev_q;

    // Remember last cycle's synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= level;
    end

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            trig_mode_e mode;

            // Select the trigger mode and gate it by the mask bit
            always_comb begin
                mode   = trig_mode_e'({edge_sel[i], pol[i]});
                evt[i] = mask[i] & trig_hit(mode, level[i], prev_q[i]);
            end

            // R6
            edge_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_sel[i] && evt[i]) |=>
                    (!evt[i] || !$stable({mask[i], pol[i], edge_sel[i]})));
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_combine.sv
// OR-combines line events onto the interrupt outputs selected by each line's
// index. Indices at or above NUM_IRQ reach no output. Outputs are registered.
module gpio_irq_combine
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned NUM_IRQ   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LINES-1:0]            evt,
    input  logic [NUM_LINES-1:0][IDX_W-1:0] map_q,
    output logic [NUM_IRQ-1:0]              irq_out
);

    logic [NUM_IRQ-1:0] irq_d;

    // Gather every line routed to each output
    always_comb begin
        irq_d = '0;
        for (int j = 0; j < int'(NUM_IRQ); j++) begin
            for (int i = 0; i < int'(NUM_LINES); i++) begin
                if (map_q[i] == IDX_W'(j))
                    irq_d[j] = irq_d[j] | evt[i];
            end
        end
    end

    // Register the combined interrupts
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_out <= '0;
        else
            irq_out <= irq_d;
    end

endmodule

// File: rtl/gpio_irq_router.sv
// GPIO port top: register bank, pad synchroniser, trigger detection and
// interrupt routing. Assumes 1 <= NUM_LINES <= 32 and 1 <= NUM_IRQ <= 32.
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned NUM_IRQ   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_IRQ-1:0]   irq_out
);

    logic [NUM_LINES-1:0]            sync_lvl;
    logic [NUM_LINES-1:0]            out_q;
    logic [NUM_LINES-1:0]            dir_q;
    logic [NUM_LINES-1:0]            mask_q;
    logic [NUM_LINES-1:0]            pol_q;
    logic [NUM_LINES-1:0]            edge_q;
    logic [NUM_LINES-1:0][IDX_W-1:0] map_q;
    logic [NUM_LINES-1:0]            evt;

    gpio_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_lvl)
    );

    gpio_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_lvl),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .mask_q    (mask_q),
        .pol_q     (pol_q),
        .edge_q    (edge_q),
        .map_q     (map_q)
    );

    gpio_trig_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (sync_lvl),
        .mask     (mask_q),
        .pol      (pol_q),
        .edge_sel (edge_q),
        .evt      (evt)
    );

    gpio_irq_combine #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) u_combine (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .map_q   (map_q),
        .irq_out (irq_out)
    );

    // Pads driven straight from the control registers
    always_comb begin
        pad_out = out_q;
        pad_oe  = dir_q;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && pad_oe == '0));

    // R3
    dir_to_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_DIR) |=>
            (pad_oe == $past(bus_wdata[NUM_LINES-1:0])));

    // R7
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> (irq_out == '0));

endmodule

// File: tb/gpio_irq_router_bench.sv
`timescale 1ns/1ps
module gpio_irq_router_bench;

    localparam int NL = 32;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pad_in = '0;
    logic [NL-1:0] pad_out;
    logic [NL-1:0] pad_oe;
    logic [NI-1:0] irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the interrupt configuration
    logic [31:0] m_mask, m_pol, m_edge;
    logic [4:0]  m_map [NL];

    always #2 clk = ~clk;

    gpio_irq_router #(.NUM_LINES(NL), .NUM_IRQ(NI)) u_gpio_irq_router (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    // Writes the interrupt configuration and mirrors it in the model
    task automatic set_cfg(input logic [31:0] mk, input logic [31:0] pl, input logic [31:0] ed);
        bus_write(8'h0C, mk); m_mask = mk;
        bus_write(8'h10, pl); m_pol = pl;
        bus_write(8'h14, ed); m_edge = ed;
    endtask

    task automatic set_map_word(input int w, input logic [31:0] d);
        bus_write(8'(32 + 4 * w), d);
        for (int k = 0; k < 4; k++) m_map[w*4+k] = d[8*k +: 5];
    endtask

    // Settled output for level-mode lines; edge lines are quiet when pads hold
    function automatic logic [NI-1:0] exp_level(input logic [31:0] pads);
        logic [NI-1:0] r = '0;
        for (int i = 0; i < NL; i++)
            if (m_mask[i] && !m_edge[i] && (m_pol[i] ? pads[i] : !pads[i]) && m_map[i] < NI)
                r[m_map[i]] = 1'b1;
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, v, pads;
        void'($urandom(32'd20240611));
        m_mask = '0; m_pol = '0; m_edge = '0;
        for (int i = 0; i < NL; i++) m_map[i] = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 6; a++) begin
            if (a != 0) begin
                bus_read(8'(4 * a), rd);
                chk("R1 reg reset", rd, 32'h0);
            end
        end
        for (int w = 0; w < 8; w++) begin
            bus_read(8'(32 + 4 * w), rd);
            chk("R1 map reset", rd, 32'h0);
        end
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 irq_out", {28'h0, irq_out}, 32'h0);

        // R2: readback of control registers
        for (int a = 1; a < 6; a++) begin
            v = $urandom;
            bus_write(8'(4 * a), v);
            bus_read(8'(4 * a), rd);
            chk("R2 readback", rd, v);
        end
        set_cfg(32'h0, 32'h0, 32'h0);

        // R3: pads follow output and direction registers
        bus_write(8'h04, 32'hA5A5_0F0F);
        bus_write(8'h08, 32'h00FF_FF00);
        chk("R3 pad_out", pad_out, 32'hA5A5_0F0F);
        chk("R3 pad_oe", pad_oe, 32'h00FF_FF00);

        // R9: reserved offset and out-of-map addresses
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_read(8'h18, rd);
        chk("R9 reserved read", rd, 32'h0);
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_read(8'h40, rd);
        chk("R9 beyond map read", rd, 32'h0);
        bus_read(8'h08, rd);
        chk("R9 dir untouched", rd, 32'h00FF_FF00);
        bus_read(8'h3C, rd);
        chk("R9 last map word untouched", rd, 32'h0);

        // R4: synchroniser latency on the data register
        @(negedge clk);
        bus_addr = 8'h00;
        pad_in = 32'h1234_5678;
        @(posedge clk); #1;
        chk("R4 one edge still old", bus_rdata, 32'h0);
        @(posedge clk); #1;
        chk("R4 two edges new", bus_rdata, 32'h1234_5678);
        @(negedge clk); pad_in = '0;
        wait_edges(3);

        // R8: map byte layout, upper bits of each byte read as 0
        set_map_word(1, 32'hFF03_E102);
        bus_read(8'h24, rd);
        chk("R8 map readback", rd, 32'h1F03_0102);
        for (int w = 0; w < 8; w++) set_map_word(w, 32'h0);

        // R5: active-high line 5 and active-low line 9 both on output 2
        set_map_word(1, 32'h0000_0200);   // line 5 -> 2
        set_map_word(2, 32'h0000_0200);   // line 9 -> 2
        set_cfg(32'h0000_0220, 32'h0000_0020, 32'h0);
        @(negedge clk); pad_in = 32'h0000_0200;  // 5 low, 9 high: neither active
        wait_edges(4);
        chk("R5 both inactive", {28'h0, irq_out}, 32'h0);
        @(negedge clk); pad_in = 32'h0000_0220;  // line 5 high
        wait_edges(2);
        chk("R5 not yet at edge 2", {28'h0, irq_out}, 32'h0);
        wait_edges(1);
        chk("R5 high level at edge 3", {28'h0, irq_out}, 32'h4);
        @(negedge clk); pad_in = 32'h0000_0000;  // line 5 low, line 9 low active
        wait_edges(4);
        chk("R5 low level OR", {28'h0, irq_out}, 32'h4);

        // R7: clearing the mask silences the output
        bus_write(8'h0C, 32'h0); m_mask = '0;
        wait_edges(1);
        chk("R7 mask clear", {28'h0, irq_out}, 32'h0);

        // R6: rising edge on line 3 to output 1
        set_map_word(0, 32'h0100_0000);
        set_map_word(1, 32'h0);
        set_map_word(2, 32'h0);
        set_cfg(32'h8, 32'h8, 32'h8);
        wait_edges(2);
        @(negedge clk); pad_in = 32'h8;
        wait_edges(2);
        chk("R6 rise not yet", {28'h0, irq_out}, 32'h0);
        wait_edges(1);
        chk("R6 rise pulse", {28'h0, irq_out}, 32'h2);
        wait_edges(1);
        chk("R6 rise one cycle", {28'h0, irq_out}, 32'h0);
        // Falling edge mode on the same line
        bus_write(8'h10, 32'h0); m_pol = '0;
        wait_edges(2);
        chk("R6 idle high no pulse", {28'h0, irq_out}, 32'h0);
        @(negedge clk); pad_in = 32'h0;
        wait_edges(3);
        chk("R6 fall pulse", {28'h0, irq_out}, 32'h2);
        wait_edges(1);
        chk("R6 fall one cycle", {28'h0, irq_out}, 32'h0);

        // R8: unrouted index 7 drives nothing even when the line is active
        set_map_word(0, 32'h0700_0000);
        set_cfg(32'h8, 32'h8, 32'h0);
        @(negedge clk); pad_in = 32'h8;
        wait_edges(4);
        chk("R8 unrouted index", {28'h0, irq_out}, 32'h0);

        // Random configurations and pads, level model on settled outputs
        for (int it = 0; it < 40; it++) begin
            set_cfg($urandom, $urandom, $urandom & $urandom);
            for (int w = 0; w < 8; w++) set_map_word(w, $urandom & 32'h0707_0707);
            wait_edges(1);
            pads = $urandom;
            @(negedge clk); pad_in = pads;
            wait_edges(4);
            chk("R5 R7 R8 random settled", {28'h0, irq_out}, {28'h0, exp_level(pads)});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule